// File: doc/BRIEF.md
# Tracking Angle Up/Down Counter

This block is the digital heart of a tracking angle-to-digital converter. It keeps a binary-weighted shaft angle in a register whose top bit is worth half a turn (180 degrees) and whose next bit is worth a quarter turn (90 degrees). The full word wraps around once per revolution. The word feeds the sine and cosine multiplying converters outside the block. Those converters and the phase detector produce a DC error proportional to sin(theta - phi). Here theta is the true shaft angle and phi is the counted angle.

The phase detector turns that error into pulses. A pulse-enable input says that the error lies outside a one-LSB deadband, so a step is wanted. A direction input gives the sign of the error. Each enabled clock moves the counter exactly one code toward the shaft angle. Over many cycles the count closes on theta. While no step is requested, a quiet-cycle timer runs. After a set number of consecutive quiet cycles, the block raises its lock flag. Any step drops the flag again.

Top module: `trk_angle_counter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `angle` is 0 and `locked` is 0.
- R2: A clock edge that samples `pulse_en`=1 with `pulse_up`=1 makes `angle` one code larger after that edge.
- R3: A clock edge that samples `pulse_en`=1 with `pulse_up`=0 makes `angle` one code smaller after that edge.
- R4: Stepping up from the all-ones code (full scale minus one LSB) gives code 0.
- R5: Stepping down from code 0 gives the all-ones code.
- R6: A clock edge that samples `pulse_en`=0 leaves `angle` unchanged, whatever the value of `pulse_up`.
- R7: `locked` is 1 exactly when the last LOCK_CYCLES sampled edges all had `pulse_en`=0. It then stays 1 for as long as `pulse_en` stays 0.
- R8: After any edge that takes a step, `locked` is 0.
- R9: Suppose the error pulses come from sin(theta - phi), with phi = angle*360/2^ANGLE_W degrees and a deadband of less than one LSB. Then the counter reaches a code within one LSB of theta along the shorter way round, including across the 0/360 boundary, and it locks there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pulse_en | input | 1 | Error is outside the deadband: take one step this cycle |
| pulse_up | input | 1 | Error sign: 1 counts up, 0 counts down |
| angle | output | ANGLE_W | Counted angle, natural binary; MSB weighs 180 degrees |
| locked | output | 1 | Loop has been quiet for LOCK_CYCLES consecutive cycles |

## Verification
The bound checker watches the local step rules on every cycle. It checks that the count holds when there is no pulse, that each enabled edge moves the count by exactly one code in the signed direction, and that both wrap points behave. It also checks that a step clears the lock flag, that the flag holds through a quiet stretch, and that it only rises after a quiet edge. The exact quiet-cycle count before lock and the reset values are shown by the bench scenarios. The bench alone can show closed-loop convergence, because it needs a behavioural sine error. This covers settling within one LSB of several targets, and taking the short path through zero.

// File: rtl/trk_angle_pkg.sv
package trk_angle_pkg;

    // Step requested for the current cycle
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

endpackage

// File: rtl/trk_step_decode.sv
module trk_step_decode
    import trk_angle_pkg::*;
(
    input  logic  pulse_en,
    input  logic  pulse_up,
    output step_e step
);

    always_comb begin
        if (!pulse_en) begin
            step = STEP_HOLD;
        end else if (pulse_up) begin
            step = STEP_UP;
        end else begin
            step = STEP_DOWN;
        end
    end

endmodule

// File: rtl/trk_angle_next.sv
module trk_angle_next
    import trk_angle_pkg::*;
#(
    parameter int ANGLE_W = 12
) (
    input  logic [ANGLE_W-1:0] angle_q,
    input  step_e              step,
    output logic [ANGLE_W-1:0] angle_d
);

    localparam logic [ANGLE_W-1:0] ONE_LSB = {{(ANGLE_W-1){1'b0}}, 1'b1};

    // Modulo 2^ANGLE_W arithmetic: one revolution wraps naturally
    always_comb begin
        unique case (step)
            STEP_UP:   angle_d = angle_q + ONE_LSB;
            STEP_DOWN: angle_d = angle_q - ONE_LSB;
            default:   angle_d = angle_q;
        endcase
    end

endmodule

// File: rtl/trk_quiet_timer.sv
module trk_quiet_timer
    import trk_angle_pkg::*;
#(
    parameter int LOCK_CYCLES = 4,
    parameter int QW          = $clog2(LOCK_CYCLES + 1)
) (
    input  logic [QW-1:0] quiet_q,
    input  step_e         step,
    output logic [QW-1:0] quiet_d,
    output logic          locked
);

    localparam logic [QW-1:0] QUIET_MAX = QW'(LOCK_CYCLES);

    assign locked = (quiet_q == QUIET_MAX);

    always_comb begin
        if (step != STEP_HOLD) begin
            quiet_d = '0;
        end else if (quiet_q == QUIET_MAX) begin
            quiet_d = quiet_q;
        end else begin
            quiet_d = quiet_q + QW'(1);
        end
    end

endmodule

// File: rtl/trk_angle_counter.sv
module trk_angle_counter
    import trk_angle_pkg::*;
#(
    parameter int ANGLE_W     = 12,
    parameter int LOCK_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pulse_en,
    input  logic               pulse_up,
    output logic [ANGLE_W-1:0] angle,
    output logic               locked
);

    localparam int QW = $clog2(LOCK_CYCLES + 1);

    typedef struct packed {
        logic [ANGLE_W-1:0] angle;
        logic [QW-1:0]      quiet;
    } trk_state_t;

    trk_state_t state_q;
    trk_state_t state_d;

    step_e              step;
    logic [ANGLE_W-1:0] angle_nx;
    logic [QW-1:0]      quiet_nx;
    logic               locked_w;

    trk_step_decode u_decode (
        .pulse_en (pulse_en),
        .pulse_up (pulse_up),
        .step     (step)
    );

    trk_angle_next #(
        .ANGLE_W (ANGLE_W)
    ) u_next (
        .angle_q (state_q.angle),
        .step    (step),
        .angle_d (angle_nx)
    );

    trk_quiet_timer #(
        .LOCK_CYCLES (LOCK_CYCLES),
        .QW          (QW)
    ) u_quiet (
        .quiet_q (state_q.quiet),
        .step    (step),
        .quiet_d (quiet_nx),
        .locked  (locked_w)
    );

    always_comb begin
        state_d       = state_q;
        state_d.angle = angle_nx;
        state_d.quiet = quiet_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign angle  = state_q.angle;
    assign locked = locked_w;

endmodule

// File: rtl/trk_angle_counter_chk.sv
module trk_angle_counter_chk #(
    parameter int ANGLE_W     = 12,
    parameter int LOCK_CYCLES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pulse_en,
    input logic               pulse_up,
    input logic [ANGLE_W-1:0] angle,
    input logic               locked
);

    localparam logic [ANGLE_W-1:0] ONE_LSB = {{(ANGLE_W-1){1'b0}}, 1'b1};

    p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_en && pulse_up) |=> (angle == $past(angle) + ONE_LSB));

    p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_en && !pulse_up) |=> (angle == $past(angle) - ONE_LSB));

    p_wrap_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_en && pulse_up && (&angle)) |=> (angle == '0));

    p_wrap_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_en && !pulse_up && (angle == '0)) |=> (&angle));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_en |=> $stable(angle));

    p_stay_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_en && locked) |=> locked);

    p_lock_after_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(!pulse_en));

    p_unlock_on_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_en |=> !locked);

endmodule

bind trk_angle_counter trk_angle_counter_chk #(
    .ANGLE_W     (ANGLE_W),
    .LOCK_CYCLES (LOCK_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pulse_en (pulse_en),
    .pulse_up (pulse_up),
    .angle    (angle),
    .locked   (locked)
);

// File: tb/trk_angle_counter_tb.sv
module trk_angle_counter_tb;

    localparam int  W     = 12;
    localparam int  LOCK  = 4;
    localparam int  NCODE = 1 << W;
    localparam real PI    = 3.14159265358979;

    typedef struct {
        int    angle;
        bit    locked;
        string tag;
    } exp_t;

    logic         clk;
    logic         rst_n;
    logic         pulse_en;
    logic         pulse_up;
    logic [W-1:0] angle;
    logic         locked;

    int   total;
    int   bad;
    int   m_angle;
    int   m_quiet;
    int   cycles;
    bit   done;
    exp_t sb[$];

    trk_angle_counter #(
        .ANGLE_W     (W),
        .LOCK_CYCLES (LOCK)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_en (pulse_en),
        .pulse_up (pulse_up),
        .angle    (angle),
        .locked   (locked)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total = total + 1;
            if (int'(angle) != e.angle || locked != e.locked) begin
                bad = bad + 1;
                $display("FAIL %s: actual angle=%0d locked=%0b expected angle=%0d locked=%0b",
                         e.tag, angle, locked, e.angle, e.locked);
            end
        end
    end

    // Driver: apply one cycle of stimulus, then push the model's expectation
    task automatic drive(input bit en, input bit up, input string tag);
        exp_t e;
        pulse_en = en;
        pulse_up = up;
        @(posedge clk);
        if (en) begin
            m_angle = up ? (m_angle + 1) % NCODE : (m_angle + NCODE - 1) % NCODE;
            m_quiet = 0;
        end else if (m_quiet < LOCK) begin
            m_quiet = m_quiet + 1;
        end
        e.angle  = m_angle;
        e.locked = (m_quiet == LOCK);
        e.tag    = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R9: closed loop against a behavioural sine error
    task automatic track(input real theta_deg);
        real thr;
        real phi;
        real err;
        real tcode;
        real diff;
        int  quiet_run;
        thr       = $sin(0.75 * 2.0 * PI / NCODE);
        quiet_run = 0;
        for (int i = 0; i < NCODE + 64 && quiet_run < LOCK + 2; i++) begin
            phi = real'(angle) * 360.0 / NCODE;
            err = $sin((theta_deg - phi) * PI / 180.0);
            if (err < thr && err > -thr) begin
                quiet_run = quiet_run + 1;
                drive(1'b0, 1'b0, "R9 loop hold");
            end else begin
                quiet_run = 0;
                drive(1'b1, err > 0.0, "R9 loop step");
            end
        end
        tcode = theta_deg * NCODE / 360.0;
        diff  = real'(angle) - tcode;
        if (diff > NCODE / 2) diff = diff - NCODE;
        if (diff < -(NCODE / 2)) diff = diff + NCODE;
        check(diff <= 1.0 && diff >= -1.0, "R9 settle within 1 LSB",
              int'(angle), int'(tcode));
        check(locked == 1'b1, "R9 locked at target", int'(locked), 1);
    endtask

    initial begin
        total    = 0;
        bad      = 0;
        cycles   = 0;
        done     = 1'b0;
        m_angle  = 0;
        m_quiet  = 0;
        rst_n    = 1'b0;
        pulse_en = 1'b1;
        pulse_up = 1'b1;
        repeat (3) @(negedge clk);
        check(angle == '0, "R1 reset angle", int'(angle), 0);
        check(locked == 1'b0, "R1 reset locked", int'(locked), 0);
        pulse_en = 1'b0;
        rst_n    = 1'b1;
        check(angle == '0 && locked == 1'b0, "R1 after release", int'(angle), 0);

        // R2: count up
        for (int i = 0; i < 5; i++) drive(1'b1, 1'b1, "R2 step up");
        // R3: count down
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, "R3 step down");
        // R5: down past zero
        for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, "R5 wrap down");
        // R6: quiet cycles with the direction toggling; R7 lock
        for (int i = 0; i < LOCK + 3; i++) drive(1'b0, i[0], "R6 R7 hold and lock");
        // R8: a single step drops lock
        drive(1'b1, 1'b1, "R8 step clears lock");
        // R7: lock needs the full quiet count again
        for (int i = 0; i < LOCK - 1; i++) drive(1'b0, 1'b1, "R7 not yet locked");
        drive(1'b1, 1'b0, "R8 step before lock");
        // R4: climb to the all-ones code, then wrap up
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b1, "R4 wrap up");
        for (int i = 0; i < LOCK; i++) drive(1'b0, 1'b0, "R7 lock again");

        track(100.37);
        track(350.1);
        track(10.2);
        track(200.9);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule